// File: doc/BRIEF.md
# Battery Level LED Bar Display

This block drives a five-segment bar of LEDs. The bar shows how much charge a battery has left, as a fraction of the capacity it holds when full. Two counts come in: the present capacity and the full-capacity reference. The block sorts their ratio into one of six bands and lights a thermometer-style bar from segment 0 upward. When the battery is close to empty, or an end-of-discharge voltage flag is raised, only segment 0 is used, and it flashes at 4 Hz.

The bar is normally dark. It comes on while an activity flag reports that the capacity count is moving, in charge or in discharge, faster than a threshold rate. It also comes on for a fixed four-second window after a push-button request, which is an active-low input. A periodic tick input, `TICK_HZ` pulses per second, sets all timing. The band comparisons multiply instead of divide, so no divider is needed.

Top module: `batt_bar_display`

## Requirements
- R1: With `cap_full` nonzero and `cap_now*100 >= cap_full*80`, the displayed value of `seg_en` is 5'b11111. Bit 0 is the first (lowest) segment.
- R2: For ratios in [60,80) % the bar is 5'b01111. For [40,60) % it is 5'b00111. For [20,40) % it is 5'b00011. Each lower bound is compared as `cap_now*100 >= cap_full*T`.
- R3: For ratios in [6,20) % the bar is 5'b00001, and it does not blink.
- R4: When `cap_now*100 < cap_full*6`, or when `cap_full` is zero, bits 4..1 are 0 and bit 0 follows the blink phase.
- R5: When `edv_flag` is 1, the blinking low pattern of R4 is shown whatever the ratio.
- R6: The blink phase starts at 0 after reset. It inverts after every `TICK_HZ/8` ticks, which gives a 4 Hz square wave with 50 % duty.
- R7: While `disp_req_n` is 0 the display is enabled. After it returns to 1, the display stays enabled until `4*TICK_HZ` further ticks have arrived.
- R8: A new request that arrives while the hold window is running restarts the full `4*TICK_HZ`-tick window.
- R9: While `active_flag` is 1 the display is enabled, whatever the state of the hold timer.
- R10: While the display is not enabled, `seg_en` is 5'b00000 at every level.
- R11: While `rst` is high and on the first edge after it, `seg_en` is 5'b00000.
- R12: `seg_en` is registered. It reflects the inputs present at the clock edge that produces it, so it takes one edge of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | One-cycle pulse, `TICK_HZ` times per second |
| cap_now | input | CAP_W | Present remaining capacity count |
| cap_full | input | CAP_W | Full-capacity reference count |
| edv_flag | input | 1 | End-of-discharge voltage reached |
| active_flag | input | 1 | Charge or discharge activity above threshold rate |
| disp_req_n | input | 1 | Display request button, active low |
| seg_en | output | 5 | Segment enables, active high, bit 0 lowest |

## Verification
The hardest situation to reach is the exact end of the hold window, especially after a request has restarted it partway through. The bench switches the activity flag off and holds a full-bar level, so that blinking cannot mask the result. It then counts ticks one by one after the button is released and checks that the bar is still lit after `4*TICK_HZ-1` ticks and dark after the next one. The band edges are covered by sweeping every `cap_now` value against several `cap_full` values, including zero and values that do not divide 100 evenly.

// File: rtl/bbd_pkg.sv
package bbd_pkg;

    localparam int unsigned NUM_SEG   = 5;
    localparam int unsigned NUM_EDGES = 5;

    // Lower band edges in percent, ascending
    localparam int unsigned EDGE_PCT [NUM_EDGES] = '{6, 20, 40, 60, 80};

    typedef enum logic [2:0] {
        BAND_LOW  = 3'd0,
        BAND_ONE  = 3'd1,
        BAND_TWO  = 3'd2,
        BAND_THR  = 3'd3,
        BAND_FOUR = 3'd4,
        BAND_FULL = 3'd5
    } band_t;

    typedef logic [NUM_SEG-1:0] seg_t;

    // Thermometer fill; the low band shows only the blink phase on segment 0
    function automatic seg_t band_pattern(input band_t b, input logic phase);
        seg_t p;
        case (b)
            BAND_FULL: p = 5'b11111;
            BAND_FOUR: p = 5'b01111;
            BAND_THR:  p = 5'b00111;
            BAND_TWO:  p = 5'b00011;
            BAND_ONE:  p = 5'b00001;
            default:   p = {4'b0000, phase};
        endcase
        return p;
    endfunction

endpackage

// File: rtl/bbd_band_sel.sv
module bbd_band_sel
    import bbd_pkg::*;
#(
    parameter int unsigned CAP_W = 16
) (
    input  logic [CAP_W-1:0] cap_now,
    input  logic [CAP_W-1:0] cap_full,
    input  logic             edv_flag,
    output band_t            band
);
    localparam int unsigned PW = CAP_W + 7;

    logic [PW-1:0]        now_scaled;
    logic [NUM_EDGES-1:0] above;

    assign now_scaled = PW'(cap_now) * PW'(100);

    genvar gi;
    generate
        for (gi = 0; gi < NUM_EDGES; gi++) begin : g_edge
            logic [PW-1:0] limit;
            assign limit     = PW'(cap_full) * PW'(EDGE_PCT[gi]);
            assign above[gi] = (now_scaled >= limit);
        end
    endgenerate

    always_comb begin
        if (edv_flag || (cap_full == '0))
            band = BAND_LOW;
        else
            band = band_t'(3'($countones(above)));
    end

endmodule

// File: rtl/bbd_blink.sv
module bbd_blink #(
    parameter int unsigned TICK_HZ = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    output logic phase
);
    localparam int unsigned HALF_TICKS = (TICK_HZ / 8 < 1) ? 1 : TICK_HZ / 8;
    localparam int unsigned DW = $clog2(HALF_TICKS) + 1;

    logic [DW-1:0] div_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_cnt <= '0;
            phase   <= 1'b0;
        end else if (tick) begin
            if (div_cnt == DW'(HALF_TICKS - 1)) begin
                div_cnt <= '0;
                phase   <= ~phase;
            end else begin
                div_cnt <= div_cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/bbd_hold.sv
module bbd_hold #(
    parameter int unsigned TICK_HZ = 64,
    localparam int unsigned HOLD_TICKS = 4 * TICK_HZ,
    localparam int unsigned HW = $clog2(HOLD_TICKS + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          req_n,
    output logic [HW-1:0] hold_cnt,
    output logic          hold_on
);
    always_ff @(posedge clk) begin
        if (rst)
            hold_cnt <= '0;
        else if (!req_n)
            hold_cnt <= HW'(HOLD_TICKS);
        else if (tick && (hold_cnt != '0))
            hold_cnt <= hold_cnt - 1'b1;
    end

    assign hold_on = (hold_cnt != '0);

endmodule

// File: rtl/batt_bar_display.sv
module batt_bar_display
    import bbd_pkg::*;
#(
    parameter int unsigned CAP_W   = 16,
    parameter int unsigned TICK_HZ = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic [CAP_W-1:0] cap_now,
    input  logic [CAP_W-1:0] cap_full,
    input  logic             edv_flag,
    input  logic             active_flag,
    input  logic             disp_req_n,
    output logic [4:0]       seg_en
);
    localparam int unsigned HW = $clog2(4 * TICK_HZ + 1);

    band_t         band_now;
    logic          blink_ph;
    logic [HW-1:0] hold_cnt;
    logic          hold_on;
    logic          disp_on;

    bbd_band_sel #(.CAP_W(CAP_W)) u_band (
        .cap_now  (cap_now),
        .cap_full (cap_full),
        .edv_flag (edv_flag),
        .band     (band_now)
    );

    bbd_blink #(.TICK_HZ(TICK_HZ)) u_blink (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick),
        .phase (blink_ph)
    );

    bbd_hold #(.TICK_HZ(TICK_HZ)) u_hold (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .req_n    (disp_req_n),
        .hold_cnt (hold_cnt),
        .hold_on  (hold_on)
    );

    assign disp_on = active_flag || hold_on;

    always_ff @(posedge clk) begin
        if (rst)
            seg_en <= '0;
        else if (disp_on)
            seg_en <= band_pattern(band_now, blink_ph);
        else
            seg_en <= '0;
    end

endmodule

// File: rtl/bbd_checker.sv
module bbd_checker
    import bbd_pkg::*;
#(
    parameter int unsigned TICK_HZ = 64,
    localparam int unsigned HOLD_TICKS = 4 * TICK_HZ,
    localparam int unsigned HW = $clog2(HOLD_TICKS + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          tick,
    input logic          active_flag,
    input logic          disp_req_n,
    input logic [4:0]    seg_en,
    input band_t         band_now,
    input logic          blink_ph,
    input logic [HW-1:0] hold_cnt
);
    AST_RESET_DARK: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (seg_en == 5'b00000));  // R11

    AST_DARK_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        (!active_flag && hold_cnt == '0) |=> (seg_en == 5'b00000));  // R10

    AST_LOW_UPPER_OFF: assert property (@(posedge clk) disable iff (rst)
        (band_now == BAND_LOW) |=> (seg_en[4:1] == 4'b0000));  // R4

    AST_THERMO_FILL: assert property (@(posedge clk) disable iff (rst)
        ((seg_en & (seg_en + 5'd1)) == 5'b00000));  // R1

    AST_HOLD_RELOAD: assert property (@(posedge clk) disable iff (rst)
        !disp_req_n |=> (hold_cnt == HW'(HOLD_TICKS)));  // R8

    AST_HOLD_STEP: assert property (@(posedge clk) disable iff (rst)
        (disp_req_n && tick && hold_cnt != '0) |=> (hold_cnt == $past(hold_cnt) - 1'b1));  // R7

    AST_BLINK_STABLE: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(blink_ph));  // R6

    AST_ACTIVE_SHOWS: assert property (@(posedge clk) disable iff (rst)
        (active_flag && band_now != BAND_LOW) |=> (seg_en[0] == 1'b1));  // R9

endmodule

bind batt_bar_display bbd_checker #(.TICK_HZ(TICK_HZ)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .tick        (tick),
    .active_flag (active_flag),
    .disp_req_n  (disp_req_n),
    .seg_en      (seg_en),
    .band_now    (band_now),
    .blink_ph    (blink_ph),
    .hold_cnt    (hold_cnt)
);

// File: tb/sim_batt_bar_display.sv
`timescale 1ns/1ps
module sim_batt_bar_display;

    localparam int unsigned CAP_W   = 8;
    localparam int unsigned TICK_HZ = 8;
    localparam int unsigned HALF    = TICK_HZ / 8;
    localparam int unsigned HOLD    = 4 * TICK_HZ;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             tick = 1'b0;
    logic [CAP_W-1:0] cap_now = '0;
    logic [CAP_W-1:0] cap_full = '0;
    logic             edv_flag = 1'b0;
    logic             active_flag = 1'b0;
    logic             disp_req_n = 1'b1;
    logic [4:0]       seg_en;

    int checks = 0;
    int errors = 0;
    int ticks_seen = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    batt_bar_display #(.CAP_W(CAP_W), .TICK_HZ(TICK_HZ)) u0 (
        .clk(clk), .rst(rst), .tick(tick), .cap_now(cap_now), .cap_full(cap_full),
        .edv_flag(edv_flag), .active_flag(active_flag), .disp_req_n(disp_req_n),
        .seg_en(seg_en)
    );

    function automatic logic model_phase();
        return logic'((ticks_seen / HALF) % 2);
    endfunction

    function automatic logic [4:0] model_bar(int now, int full, bit edv);
        int n;
        if (edv || full == 0 || now * 100 < full * 6) return {4'b0000, model_phase()};
        n = 1;
        if (now * 100 >= full * 20) n = 2;
        if (now * 100 >= full * 40) n = 3;
        if (now * 100 >= full * 60) n = 4;
        if (now * 100 >= full * 80) n = 5;
        return 5'((1 << n) - 1);
    endfunction

    task automatic check(string tag, logic [4:0] exp);
        checks++;
        if (seg_en !== exp) begin
            errors++;
            $display("FAIL %s: seg_en=%b expected=%b", tag, seg_en, exp);
        end
    endtask

    task automatic cyc(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_tick();
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        ticks_seen++;
    endtask

    initial begin
        int fulls [6] = '{0, 1, 7, 50, 100, 255};
        string tag;
        @(negedge clk);
        active_flag = 1'b1;
        cap_now = 8'd100;
        cap_full = 8'd100;
        cyc(3);
        check("R11 reset dark", 5'b00000);
        rst = 1'b0;
        @(negedge clk);
        check("R12 first edge after reset", 5'b11111);

        // R1 R2 R3 R4 R12: sweep every level against several references
        for (int f = 0; f < 6; f++) begin
            for (int v = 0; v < 256; v++) begin
                cap_full = CAP_W'(fulls[f]);
                cap_now  = CAP_W'(v);
                @(negedge clk);
                if (fulls[f] == 0 || v * 100 < fulls[f] * 6) tag = "R4 low band";
                else if (v * 100 < fulls[f] * 20) tag = "R3 one segment";
                else if (v * 100 < fulls[f] * 80) tag = "R2 mid band";
                else tag = "R1 full band";
                check(tag, model_bar(v, fulls[f], 1'b0));
            end
        end

        // R5: end-of-discharge flag forces blink pattern at full level
        cap_now = 8'd200; cap_full = 8'd200; edv_flag = 1'b1;
        @(negedge clk);
        check("R5 edv forces low", {4'b0000, model_phase()});
        pulse_tick(); @(negedge clk);
        check("R5 edv blink phase", {4'b0000, model_phase()});
        edv_flag = 1'b0;
        @(negedge clk);
        check("R5 edv released", 5'b11111);

        // R6: blink toggles every HALF ticks; R3 band does not blink
        cap_now = 8'd2; cap_full = 8'd100;
        for (int k = 0; k < 8; k++) begin
            pulse_tick(); @(negedge clk);
            check("R6 blink phase", {4'b0000, model_phase()});
        end
        cap_now = 8'd10;
        for (int k = 0; k < 3; k++) begin
            pulse_tick(); @(negedge clk);
            check("R3 steady", 5'b00001);
        end

        // R9 R10: activity flag and dark display
        cap_now = 8'd100;
        active_flag = 1'b0;
        cyc(2);
        check("R10 inactive dark", 5'b00000);
        active_flag = 1'b1;
        @(negedge clk);
        check("R9 activity enables", 5'b11111);
        active_flag = 1'b0;
        @(negedge clk);
        check("R10 dark again", 5'b00000);

        // R7: hold window length
        disp_req_n = 1'b0;
        cyc(2);
        check("R7 on during request", 5'b11111);
        disp_req_n = 1'b1;
        for (int k = 0; k < HOLD - 1; k++) pulse_tick();
        cyc(2);
        check("R7 still on before last tick", 5'b11111);
        pulse_tick(); cyc(2);
        check("R7 off after hold", 5'b00000);

        // R8: restart during hold
        disp_req_n = 1'b0; cyc(2); disp_req_n = 1'b1;
        for (int k = 0; k < 20; k++) pulse_tick();
        disp_req_n = 1'b0; cyc(2); disp_req_n = 1'b1;
        for (int k = 0; k < HOLD - 1; k++) pulse_tick();
        cyc(2);
        check("R8 restarted window on", 5'b11111);
        pulse_tick(); cyc(2);
        check("R8 restarted window off", 5'b00000);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule